// File: doc/BRIEF.md
# Two-Byte Receive Byte Orderer

This block sits on a 16-bit receive path that carries two bytes per word. In time order the lower byte (bits 7:0) comes before the upper byte (bits 15:8). The block hunts for a configurable marker byte. If the marker turns up in the upper lane, the block inserts one configurable filler byte ahead of it. From then on the marker leaves in the lower lane, and every later word is rebuilt from two neighbouring input words.

A hunt starts on a rising edge of a trigger. A static mode input selects which trigger counts: the word aligner's lock indication, or a user start line. The lock flag rises with the first output word that has been put in order. Each new trigger edge drops the flag and starts the hunt again. The block itself does no word alignment, no deserialization and no clock crossing.

Top module: `bord_top`

## Requirements
- R1: After a synchronous active-high reset, `out_valid`, `aligned` and `out_data` are all zero. No shift is applied and no hunt is active.
- R2: Each output word appears one clock after its input word, and `out_valid` is `in_valid` delayed by one cycle. With no shift in force, `out_data` equals the input word.
- R3: With `mode_user` = 0, a 0-to-1 transition of `sync_ok`, compared with its value at the previous clock, starts a hunt. On the next cycle `aligned` is 0. A level that stays high starts nothing further. `user_go` has no effect in this mode.
- R4: With `mode_user` = 1, a rising edge of `user_go` starts the hunt. `sync_ok` has no effect in this mode.
- R5: During a hunt, a valid word whose lower byte equals the marker ends the hunt with no filler. That word leaves unchanged, any earlier shift is dropped, and `aligned` is 1 in the same cycle as that output word. If both lanes match, the lower lane wins.
- R6: During a hunt, a valid word whose upper byte (and not its lower byte) equals the marker ends the hunt with one filler. That word's output is {filler in bits 15:8, its own lower byte in bits 7:0}, and `aligned` rises with it.
- R7: While the shift is in force, each output word is {current lower byte in 15:8, previous valid word's upper byte in 7:0}, so no byte is lost. A new hunt keeps the existing shift until the hunt decides again.
- R8: Invalid input words are neither searched nor shifted, and `out_data` holds its last value in the cycle after one.
- R9: The marker and filler values are captured only on cycles when no hunt is running. Changes made during a hunt take effect only after it ends.
- R10: A trigger edge during a hunt restarts it. The word presented in the trigger-edge cycle is never examined.
- R11: Once ordered, later marker bytes in either lane do not change the shift or the flag until the next trigger edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_user | input | 1 | Static trigger select: 0 lock indication, 1 user start |
| sync_ok | input | 1 | Word aligner lock indication |
| user_go | input | 1 | User start line |
| order_pat | input | 8 | Marker byte to hunt for |
| pad_pat | input | 8 | Filler byte to insert |
| in_valid | input | 1 | Qualifies `in_data` |
| in_data | input | 16 | Two-byte input word, lower byte earlier |
| out_valid | output | 1 | Qualifies `out_data` |
| out_data | output | 16 | Reordered output word |
| aligned | output | 1 | Byte order established since last trigger edge |

## Verification
The assertions assume that `mode_user` changes only while reset is asserted. They also assume that both trigger inputs are low when reset is released, so that a level left over from before reset does not count as an edge. The stimulus changes the mode only around a reset pulse and clears both triggers before each reset. It drives every input at the falling edge. The reference model in the scoreboard sees each trigger transition in the same cycle as the design.

// File: rtl/bord_pkg.sv
package bord_pkg;

    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned WORD_W  = 2 * BYTE_W;
    localparam int unsigned N_TRIG  = 2;
    localparam int unsigned TRIG_SY = 0;
    localparam int unsigned TRIG_US = 1;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        byte_t hi;
        byte_t lo;
    } word_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HUNT = 2'd1,
        ST_LOCK = 2'd2
    } hunt_st_e;

    typedef enum logic [1:0] {
        LANE_NONE = 2'd0,
        LANE_LO   = 2'd1,
        LANE_HI   = 2'd2
    } hit_e;

    typedef struct packed {
        logic load;
        logic shift;
    } decide_t;

    function automatic hit_e find_lane(word_t w, byte_t marker);
        if (w.lo == marker)      return LANE_LO;
        else if (w.hi == marker) return LANE_HI;
        else                     return LANE_NONE;
    endfunction

    function automatic word_t join_shifted(byte_t held, word_t cur);
        word_t r;
        r.hi = cur.lo;
        r.lo = held;
        return r;
    endfunction

    function automatic word_t pad_front(byte_t filler, word_t cur);
        word_t r;
        r.hi = filler;
        r.lo = cur.lo;
        return r;
    endfunction

endpackage

// File: rtl/bord_edge.sv
module bord_edge #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic q;

        always_ff @(posedge clk) begin
            if (rst) q <= 1'b0;
            else     q <= lvl[i];
        end

        assign rise[i] = lvl[i] & ~q;

        // R3: a held level cannot produce two edges in a row
        p_no_double_rise_r3: assert property (@(posedge clk) disable iff (rst)
            rise[i] |=> !rise[i]);
    end

endmodule

// File: rtl/bord_ctrl.sv
module bord_ctrl
    import bord_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                mode_user,
    input  logic [N_TRIG-1:0]   rise,
    input  logic                in_valid,
    input  word_t               in_word,
    input  byte_t               order_pat,
    input  byte_t               pad_pat,
    output decide_t             dec,
    output byte_t               pad_q,
    output logic                aligned
);

    hunt_st_e st;
    byte_t    pat_q;
    logic     trig;
    logic     examine;
    hit_e     hit;

    assign trig    = mode_user ? rise[TRIG_US] : rise[TRIG_SY];
    assign examine = (st == ST_HUNT) && in_valid && !trig;
    assign hit     = find_lane(in_word, pat_q);

    always_comb begin
        dec.load  = examine && (hit != LANE_NONE);
        dec.shift = (hit == LANE_HI);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pat_q <= '0;
            pad_q <= '0;
        end else if (st != ST_HUNT) begin
            pat_q <= order_pat;
            pad_q <= pad_pat;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            aligned <= 1'b0;
        end else if (trig) begin
            st      <= ST_HUNT;
            aligned <= 1'b0;
        end else if (dec.load) begin
            st      <= ST_LOCK;
            aligned <= 1'b1;
        end
    end

    // R3: a trigger edge drops the flag and opens a hunt
    p_trig_clears_r3: assert property (@(posedge clk) disable iff (rst)
        trig |=> (!aligned && st == ST_HUNT));

    // R5: a decision raises the flag
    p_decide_sets_r5: assert property (@(posedge clk) disable iff (rst)
        dec.load |=> aligned);

    // R11: the flag only stands in the locked state
    p_flag_locked_r11: assert property (@(posedge clk) disable iff (rst)
        aligned |-> (st == ST_LOCK));

    // R9: the marker is frozen while hunting
    p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        (st == ST_HUNT) |=> $stable(pat_q));

    // R10: the edge cycle is never examined
    p_edge_not_seen_r10: assert property (@(posedge clk) disable iff (rst)
        trig |-> !dec.load);

endmodule

// File: rtl/bord_shift.sv
module bord_shift
    import bord_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    in_valid,
    input  word_t   in_word,
    input  decide_t dec,
    input  byte_t   pad,
    output logic    out_valid,
    output word_t   out_word
);

    logic  shift_q;
    byte_t held_q;
    word_t next_word;

    always_comb begin
        if (dec.load)
            next_word = dec.shift ? pad_front(pad, in_word) : in_word;
        else
            next_word = shift_q ? join_shifted(held_q, in_word) : in_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q   <= 1'b0;
            held_q    <= '0;
            out_word  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_word <= next_word;
                held_q   <= in_word.hi;
                if (dec.load) shift_q <= dec.shift;
            end
        end
    end

    // R2: fixed one-cycle latency of the qualifier
    p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_idle_follow_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R8: gaps leave the output word untouched
    p_gap_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_word));

    // R6: filler leads the matching word
    p_pad_insert_r6: assert property (@(posedge clk) disable iff (rst)
        (dec.load && dec.shift) |=>
            (out_word.hi == $past(pad) && out_word.lo == $past(in_word.lo)));

    // R5: a lower-lane match passes the word straight
    p_lo_straight_r5: assert property (@(posedge clk) disable iff (rst)
        (dec.load && !dec.shift) |=> (out_word == $past(in_word)));

    // R7: the held byte is carried into the next word
    p_carry_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && shift_q && !dec.load) |=> (out_word.lo == $past(held_q)));

endmodule

// File: rtl/bord_top.sv
module bord_top
    import bord_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_user,
    input  logic              sync_ok,
    input  logic              user_go,
    input  logic [BYTE_W-1:0] order_pat,
    input  logic [BYTE_W-1:0] pad_pat,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic              aligned
);

    logic [N_TRIG-1:0] trig_lvl;
    logic [N_TRIG-1:0] trig_rise;
    word_t             in_word;
    word_t             out_word;
    decide_t           dec;
    byte_t             pad_q;

    always_comb begin
        trig_lvl          = '0;
        trig_lvl[TRIG_SY] = sync_ok;
        trig_lvl[TRIG_US] = user_go;
    end

    assign in_word  = word_t'(in_data);
    assign out_data = WORD_W'(out_word);

    bord_edge #(.N(N_TRIG)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (trig_lvl),
        .rise (trig_rise)
    );

    bord_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .mode_user (mode_user),
        .rise      (trig_rise),
        .in_valid  (in_valid),
        .in_word   (in_word),
        .order_pat (order_pat),
        .pad_pat   (pad_pat),
        .dec       (dec),
        .pad_q     (pad_q),
        .aligned   (aligned)
    );

    bord_shift u_shift (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_word   (in_word),
        .dec       (dec),
        .pad       (pad_q),
        .out_valid (out_valid),
        .out_word  (out_word)
    );

    // R1: nothing leaves the block straight after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!out_valid && !aligned && out_data == '0));

endmodule

// File: tb/test_bord_top.sv
module test_bord_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        mode_user;
    logic        sync_ok;
    logic        user_go;
    logic [7:0]  order_pat;
    logic [7:0]  pad_pat;
    logic        in_valid;
    logic [15:0] in_data;
    logic        out_valid;
    logic [15:0] out_data;
    logic        aligned;

    always #10 clk = ~clk;

    bord_top i_bord_top (
        .clk       (clk),
        .rst       (rst),
        .mode_user (mode_user),
        .sync_ok   (sync_ok),
        .user_go   (user_go),
        .order_pat (order_pat),
        .pad_pat   (pad_pat),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data),
        .aligned   (aligned)
    );

    typedef struct packed {
        logic        v;
        logic [15:0] d;
        logic        a;
    } exp_t;

    exp_t  q_exp[$];
    string q_tag[$];
    int    n_vec = 0;
    int    n_bad = 0;

    // pending configuration, applied on the next step
    logic [7:0] cfg_pat, cfg_pad;

    // reference state
    int          m_st;
    logic        m_shift, m_ps, m_pu, m_al, m_ov;
    logic [7:0]  m_held, m_pat, m_pad;
    logic [15:0] m_od;

    task automatic model_reset();
        m_st = 0; m_shift = 0; m_ps = 0; m_pu = 0; m_al = 0; m_ov = 0;
        m_held = 0; m_pat = 0; m_pad = 0; m_od = 0;
    endtask

    task automatic step(string tag, logic s, logic u, logic v, logic [15:0] d);
        logic rs, ru, trig, exam;
        logic [7:0] cp, cpad;
        exp_t e;
        @(negedge clk);
        sync_ok = s; user_go = u; in_valid = v; in_data = d;
        order_pat = cfg_pat; pad_pat = cfg_pad;
        rs = s & ~m_ps; ru = u & ~m_pu; m_ps = s; m_pu = u;
        trig = mode_user ? ru : rs;
        exam = (m_st == 1) && v && !trig;
        cp = m_pat; cpad = m_pad;
        if (m_st != 1) begin m_pat = cfg_pat; m_pad = cfg_pad; end
        if (v) begin
            if (exam && d[7:0] == cp) begin
                m_shift = 0; m_od = d; m_st = 2; m_al = 1;
            end else if (exam && d[15:8] == cp) begin
                m_shift = 1; m_od = {cpad, d[7:0]}; m_st = 2; m_al = 1;
            end else begin
                m_od = m_shift ? {d[7:0], m_held} : d;
            end
            m_held = d[15:8];
        end
        if (trig) begin m_st = 1; m_al = 0; end
        m_ov = v;
        e.v = m_ov; e.d = m_od; e.a = m_al;
        q_exp.push_back(e);
        q_tag.push_back(tag);
    endtask

    // monitor: compares each result away from the active edge
    always @(posedge clk) begin
        exp_t  e;
        string t;
        #5;
        if (q_exp.size() > 0) begin
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            n_vec++;
            if (out_valid !== e.v || out_data !== e.d || aligned !== e.a) begin
                n_bad++;
                $display("FAIL %s: got v=%b d=%h a=%b, expected v=%b d=%h a=%b",
                         t, out_valid, out_data, aligned, e.v, e.d, e.a);
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 0; sync_ok = 0; user_go = 0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    initial begin
        #(20 * 100000);
        n_bad++;
        $display("FAIL watchdog: got hung run, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        rst = 1; mode_user = 0; sync_ok = 0; user_go = 0;
        order_pat = 0; pad_pat = 0; in_valid = 0; in_data = 0;
        cfg_pat = 8'hBC; cfg_pad = 8'h9C;
        model_reset();
        do_reset();

        // R1: reset state
        n_vec++;
        if (out_valid !== 1'b0 || aligned !== 1'b0 || out_data !== 16'h0) begin
            n_bad++;
            $display("FAIL R1: got v=%b a=%b d=%h, expected 0 0 0000",
                     out_valid, aligned, out_data);
        end

        // R2: straight pass with no hunt, including a gap (R8)
        step("R2", 0, 0, 1, 16'h1122);
        step("R2", 0, 0, 1, 16'h3344);
        step("R8", 0, 0, 0, 16'hDEAD);
        step("R2", 0, 0, 1, 16'hBC66);

        // R3 then R5: lock indication edge, marker in lower lane
        step("R3", 1, 0, 1, 16'h01BC);
        step("R5", 1, 0, 1, 16'h0304);
        step("R5", 1, 0, 1, 16'hAABC);
        step("R11", 1, 0, 1, 16'hBC07);
        step("R3", 1, 1, 1, 16'h0809);
        step("R3", 1, 0, 1, 16'h0A0B);

        // R6, R7, R9: edge, marker changed mid-hunt, upper-lane match
        step("R3", 0, 0, 1, 16'h0C0D);
        step("R3", 1, 0, 1, 16'h1111);
        cfg_pat = 8'h33;
        step("R9", 1, 0, 1, 16'h2233);
        step("R6", 1, 0, 1, 16'hBC44);
        step("R7", 1, 0, 1, 16'h6655);
        step("R8", 1, 0, 0, 16'hFFFF);
        step("R7", 1, 0, 1, 16'h8877);
        step("R11", 1, 0, 1, 16'hBC33);
        cfg_pat = 8'hBC;
        step("R7", 1, 0, 1, 16'h9A99);

        // R10: restart during a hunt, edge-cycle word not examined
        step("R10", 0, 0, 1, 16'h1213);
        step("R10", 1, 0, 1, 16'h1415);
        step("R7", 1, 0, 1, 16'h1617);
        step("R10", 0, 0, 1, 16'h1819);
        step("R10", 1, 0, 1, 16'h20BC);
        step("R6", 1, 0, 1, 16'hBC21);
        step("R7", 1, 0, 1, 16'h2223);

        // R5: both lanes match, lower wins and shift is dropped
        step("R5", 0, 0, 1, 16'h2425);
        step("R5", 1, 0, 1, 16'h2627);
        step("R5", 1, 0, 1, 16'hBCBC);
        step("R5", 1, 0, 1, 16'h2829);

        // R4: user mode, lock indication ignored
        mode_user = 1;
        do_reset();
        cfg_pad = 8'hF7;
        step("R4", 1, 0, 1, 16'h3031);
        step("R4", 1, 0, 1, 16'hBC32);
        step("R4", 0, 0, 1, 16'h3334);
        step("R4", 1, 1, 1, 16'h3536);
        step("R4", 0, 1, 1, 16'hBC37);
        step("R7", 0, 1, 1, 16'h3839);
        step("R8", 0, 1, 0, 16'h0000);
        step("R7", 0, 0, 1, 16'h3A3B);

        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule